// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire (I2C) bus slave that fronts an on-chip byte array. It takes the raw SCL and SDA levels, samples them on the system clock, finds START, repeated START and STOP conditions, and answers to a 7-bit device address. The upper four bits of that address are fixed at binary 1010. The lower three come from strap pins. The slave pulls SDA low through an open-drain enable and never drives it high.

A master writes by sending the device address with R/W = 0, two word-address bytes (high byte first) and then data bytes. It reads by sending the device address with R/W = 1. The slave keeps one address counter that holds its value between transactions. Reads step that counter linearly across the whole array. Writes step it only within the current 32-byte page. A random read is a write header that stops after the word address, followed by a repeated START and a read. The array depth is 2^ADDR_W bytes: 4096 by default, and 8192 with ADDR_W = 13.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The slave drives ACK (SDA low) in the ninth clock of the device address byte only when that byte's bits [7:1] equal {1010, strap_i}. On a mismatch it leaves SDA released and ignores the rest of the transaction until the next START.
- R2: Bit 0 of the device address byte selects the direction: 1 starts a read, and 0 starts a write header.
- R3: In a write, the slave acknowledges the high and the low word-address byte. The counter loads {high, low} truncated to ADDR_W bits, so high-byte bits above ADDR_W-1 have no effect.
- R4: Each acknowledged data byte is stored at the counter, and the counter then advances.
- R5: During writes only counter bits [4:0] advance, wrapping from offset 31 to offset 0 of the same page. The bits above stay unchanged.
- R6: A read with no preceding address phase returns the byte at the counter, which holds the last accessed address plus one. The counter keeps its value across transactions.
- R7: A dummy write (address bytes only), then a repeated START and a read header, returns the byte at the newly loaded address.
- R8: In a read, each master ACK after a data byte makes the slave send the byte at the next address. The address wraps from 2^ADDR_W-1 to 0 and crosses page boundaries.
- R9: After a master NACK the slave stops driving SDA and sends no further bits until a new START.
- R10: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are recognised at any bit position and reset the byte state. A data byte cut short by either is not stored.
- R11: The slave changes its SDA pull only while SCL is low. Out of reset SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (as seen on the wire) |
| strap_i | input | 3 | Low three bits of the device address |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A table of single-byte writes at scattered addresses is written and then read back through random reads. A value returned from the wrong location, or a wrong counter load, shows up as a miscompare. Directed runs then separate the two wrap rules:
- a four-byte page write that straddles offset 31 must land at offsets 0 and 1 of the same page, not in the next page;
- a sequential read from the last address must continue at address 0.

Further directed runs cover the remaining cases:
- A mismatched strap or type field must get no ACK and must leave memory untouched.
- A high word-address byte with stray upper bits must alias onto the truncated address.
- An extra clock after a NACK must find SDA released even though the next byte's MSB is 0.
- A data byte cut short by STOP or by a repeated START must leave both the memory and the counter as they were.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_AHI,
    RX_ALO,
    RX_DATA
  } rxkind_e;

  // Linear step used by reads: wraps over the whole 2^w space.
  function automatic logic [15:0] step_linear(input logic [15:0] a, input int unsigned w);
    logic [15:0] m;
    m = 16'((17'd1 << w) - 17'd1);
    return (a + 16'd1) & m;
  endfunction

  // Page step used by writes: only the low pw bits count, upper bits hold.
  function automatic logic [15:0] step_page(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = 16'((17'd1 << pw) - 17'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_pipe;
  logic [LAST:0] sda_pipe;
  logic          scl_q;
  logic          sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
          sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[LAST];
      sda_q <= sda_pipe[LAST];
    end
  end

  assign scl_lvl   = scl_pipe[LAST];
  assign sda_lvl   = sda_pipe[LAST];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/eeprom_proto_ctrl.sv
module eeprom_proto_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_lvl,
  input  logic [2:0]        strap,
  input  logic [7:0]        rd_data,
  output logic              sda_pull,
  output logic              mem_we,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] addr_cnt,
  output logic              dev_done,
  output logic              dev_hit,
  output logic              tx_load
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  phase_e            phase;
  rxkind_e           kind;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [7:0]        hi_q;
  logic              rw_q;
  logic              m_ack_q;

  logic              byte_done;
  logic              ack_now;
  logic [ADDR_W-1:0] next_rd;
  logic [ADDR_W-1:0] next_wr;

  assign byte_done = (phase == PH_RX) && scl_fall && (cnt == LAST_BIT);
  assign dev_hit   = (rx_sh[7:1] == {DEV_TYPE, strap});
  assign dev_done  = byte_done && (kind == RX_DEV);
  assign ack_now   = byte_done && ((kind != RX_DEV) || dev_hit);
  assign mem_we    = byte_done && (kind == RX_DATA);
  assign wr_data   = rx_sh;
  assign tx_load   = scl_fall &&
                     (((phase == PH_RX_ACK) && (kind == RX_DEV) && rw_q) ||
                      ((phase == PH_TX_ACK) && m_ack_q));

  assign next_rd = ADDR_W'(step_linear(16'(addr_cnt), ADDR_W));
  assign next_wr = ADDR_W'(step_page(16'(addr_cnt), PAGE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= RX_DEV;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      hi_q     <= '0;
      rw_q     <= 1'b0;
      m_ack_q  <= 1'b0;
      sda_pull <= 1'b0;
      addr_cnt <= '0;
    end else if (start_evt) begin
      phase    <= PH_RX;
      kind     <= RX_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (tx_load) begin
      tx_sh    <= rd_data;
      sda_pull <= ~rd_data[7];
      addr_cnt <= next_rd;
      phase    <= PH_TX;
      cnt      <= '0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            rx_sh <= {rx_sh[6:0], sda_lvl};
            cnt   <= cnt + CNT_W'(1);
          end else if (byte_done) begin
            if (ack_now) begin
              sda_pull <= 1'b1;
              phase    <= PH_RX_ACK;
              case (kind)
                RX_DEV:  rw_q     <= rx_sh[0];
                RX_AHI:  hi_q     <= rx_sh;
                RX_ALO:  addr_cnt <= ADDR_W'({hi_q, rx_sh});
                default: addr_cnt <= next_wr;
              endcase
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            phase    <= PH_RX;
            case (kind)
              RX_DEV:  kind <= RX_AHI;
              RX_AHI:  kind <= RX_ALO;
              default: kind <= RX_DATA;
            endcase
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt <= cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_pull <= 1'b0;
              phase    <= PH_TX_ACK;
            end else begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_pull <= ~tx_sh[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            m_ack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            phase <= PH_IDLE;
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);

  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              mem_we;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] addr_cnt;
  logic              dev_done;
  logic              dev_hit;
  logic              tx_load;

  eeprom_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  eeprom_proto_ctrl #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_lvl  (sda_lvl),
    .strap    (strap_i),
    .rd_data  (rd_data),
    .sda_pull (sda_pull_o),
    .mem_we   (mem_we),
    .wr_data  (wr_data),
    .addr_cnt (addr_cnt),
    .dev_done (dev_done),
    .dev_hit  (dev_hit),
    .tx_load  (tx_load)
  );

  eeprom_byte_store #(
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr_cnt),
    .wdata(wr_data),
    .rdata(rd_data)
  );

endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_pull_o,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              dev_done,
  input logic              dev_hit,
  input logic              mem_we,
  input logic              tx_load,
  input logic [ADDR_W-1:0] addr_cnt
);

  // R11
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl);

  // R1
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !dev_hit) |=> !sda_pull_o);

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_cnt[ADDR_W-1:PAGE_W] == $past(addr_cnt[ADDR_W-1:PAGE_W])) &&
               (addr_cnt[PAGE_W-1:0] == $past(addr_cnt[PAGE_W-1:0]) + PAGE_W'(1)));

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (addr_cnt == $past(addr_cnt) + ADDR_W'(1)));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull_o);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);

endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(
  .ADDR_W(ADDR_W),
  .PAGE_W(PAGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_pull_o(sda_pull_o),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .dev_done  (dev_done),
  .dev_hit   (dev_hit),
  .mem_we    (mem_we),
  .tx_load   (tx_load),
  .addr_cnt  (addr_cnt)
);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;

  localparam int Q = 8;
  localparam int H = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NV = 8;
  // {word address, data}
  localparam logic [23:0] VEC [NV] = '{
    24'h0100A5, 24'h01013C, 24'h020058, 24'h020196,
    24'h0FFFE1, 24'h00001F, 24'h08006D, 24'h0300C4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_pull;
  logic sda_line;
  int   checks = 0;
  int   fails = 0;
  int   hi_moves = 0;
  logic prev_pull = 1'b0;
  logic prev_scl = 1'b1;
  logic [7:0] rbuf [8];

  assign sda_line = ~(m_low | sda_pull);

  always #2 clk = ~clk;

  eeprom_i2c_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .strap_i   (STRAP),
    .sda_pull_o(sda_pull)
  );

  // R11 monitor: slave pull must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && (sda_pull !== prev_pull)) hi_moves++;
    prev_pull <= sda_pull;
    prev_scl  <= scl;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    if (scl == 1'b0) begin
      m_low = 1'b0; wt(Q);
      scl = 1'b1;   wt(H);
    end
    m_low = 1'b1; wt(H);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wt(Q);
    scl = 1'b1;   wt(H);
    m_low = 1'b0; wt(H);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; wt(Q);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wt(Q);
    scl = 1'b1;   wt(H / 2);
    b = sda_line; wt(H / 2);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic x;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(x);
      v = {v[6:0], x};
    end
    send_bit(~give_ack);
  endtask

  task automatic point_to(input logic [15:0] wa, input string tag);
    logic a;
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); chk({tag, " dev-w ack"}, 16'(a), 16'h1);
    send_byte(wa[15:8], a);               chk({tag, " hi ack (R3)"}, 16'(a), 16'h1);
    send_byte(wa[7:0], a);                chk({tag, " lo ack (R3)"}, 16'(a), 16'h1);
  endtask

  task automatic write_run(input logic [15:0] wa, input logic [7:0] d0, input int n, input string tag);
    logic a;
    point_to(wa, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), a);
      chk({tag, " data ack (R4)"}, 16'(a), 16'h1);
    end
    i2c_stop();
  endtask

  task automatic read_run(input int n, input string tag);
    logic a;
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    chk({tag, " dev-r ack (R2)"}, 16'(a), 16'h1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
    i2c_stop();
  endtask

  initial begin
    logic a;
    logic x;
    logic [7:0] v;
    wt(5);
    // R11: released out of reset
    chk("R11 reset pull", 16'(sda_pull), 16'h0);
    rst_n = 1'b1;
    wt(10);
    chk("R11 reset line", 16'(sda_line), 16'h1);

    // Table walk: byte writes, then random reads back (R4, R7)
    for (int k = 0; k < NV; k++) write_run(VEC[k][23:8], VEC[k][7:0], 1, "R4 table");
    for (int k = NV - 1; k >= 0; k--) begin
      point_to(VEC[k][23:8], "R7 table");
      read_run(1, "R7 table");
      chk("R7 random read", 16'(rbuf[0]), 16'(VEC[k][7:0]));
    end

    // R1: strap mismatch and type mismatch get no ACK, write is ignored
    i2c_start();
    send_byte({4'b1010, 3'b001, 1'b0}, a); chk("R1 strap mismatch nack", 16'(a), 16'h0);
    send_byte(8'h01, a);
    send_byte(8'h00, a);
    send_byte(8'h99, a);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, STRAP, 1'b1}, a); chk("R1 type mismatch nack", 16'(a), 16'h0);
    i2c_stop();
    point_to(16'h0100, "R1");
    read_run(1, "R1");
    chk("R1 memory untouched", 16'(rbuf[0]), 16'h00A5);

    // R9 then R6: NACK releases SDA; counter persists at last+1
    point_to(16'h0100, "R9");
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    recv_byte(v, 1'b0);
    chk("R9 byte before nack", 16'(v), 16'h00A5);
    recv_bit(x);
    chk("R9 released after nack", 16'(x), 16'h1);
    i2c_stop();
    read_run(1, "R6");
    chk("R6 current read after read", 16'(rbuf[0]), 16'h003C);

    // R6/R2: current read after a byte write returns next address
    write_run(16'h0200, 8'h77, 1, "R2 write");
    read_run(1, "R6");
    chk("R6 current read after write", 16'(rbuf[0]), 16'h0096);

    // R3: upper word-address bits above ADDR_W-1 ignored
    write_run(16'hF345, 8'h5B, 1, "R3");
    point_to(16'h0345, "R3");
    read_run(1, "R3");
    chk("R3 aliased address", 16'(rbuf[0]), 16'h005B);

    // R5: page write wraps within page 0x7E0..0x7FF
    write_run(16'h07FE, 8'h40, 4, "R5");
    point_to(16'h07E0, "R5");
    read_run(2, "R5");
    chk("R5 wrapped byte 0", 16'(rbuf[0]), 16'h0042);
    chk("R5 wrapped byte 1", 16'(rbuf[1]), 16'h0043);
    // R8: read crosses the page; R5: next page untouched by the write
    point_to(16'h07FF, "R8");
    read_run(2, "R8");
    chk("R8 page last", 16'(rbuf[0]), 16'h0041);
    chk("R5 next page kept", 16'(rbuf[1]), 16'h006D);

    // R8: read wraps from the top of the array to 0
    point_to(16'h0FFF, "R8");
    read_run(3, "R8");
    chk("R8 top byte", 16'(rbuf[0]), 16'h00E1);
    chk("R8 wrapped to 0", 16'(rbuf[1]), 16'h001F);

    // R10: STOP mid data byte, then START mid byte; nothing stored, counter kept
    point_to(16'h0300, "R10");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); chk("R10 header ack", 16'(a), 16'h1);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    read_run(1, "R10");
    chk("R10 aborted byte not stored", 16'(rbuf[0]), 16'h00C4);

    // R11: pull never moved while SCL high
    chk("R11 moves while SCL high", 16'(hi_moves), 16'h0);

    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

endmodule